// File: doc/BRIEF.md
# Teletext Display Row and Window Mapper

This block sits between the display timing counters and the page-store reader of a teletext renderer. On each pixel-clock cycle it takes the current TV line number and the character column. It returns the page-store row to fetch, the scan line inside that character cell, a display enable, a box enable for picture overlay and a double-height flag. Every output is registered, so each one appears one clock after the inputs that produce it.

The vertical window has two sizes. In the 24-row mode it covers 240 lines. When either status row is enabled, the window grows to 260 lines and two extra row positions follow the main rows. A cell is 10 TV lines tall and a row holds 40 character columns.

Several controls act on the mapping:
- Magnify shows one of three fixed bands of twelve rows at double height.
- A scroll value rotates rows 1 to 23 upward. Row 0 and the status rows are never scrolled.
- The inhibit, update-key and header-suppress controls blank groups of rows.
- Per-region enables mark row 0 sub-fields and the status rows as boxes, where text appears over the picture.

Top module: `ttx_row_mapper`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs become 0 at that edge.
- R2: With both status enables low, the window covers lines 48 to 287. At position p = (line-48)/10 and scan s = (line-48)%10, `row_addr`=p and `cell_line`=s. Outputs are valid one clock after the inputs. Outside the window all outputs are 0.
- R3: With either status enable high, the window covers lines 38 to 297, with p = (line-38)/10 and s = (line-38)%10. Positions 24 and 25 are the two status rows, and `row_addr` gives 24 or 25 for them.
- R4: Status row 24 is displayed only when `stat_a_en`=1. Status row 25 is displayed only when `stat_b_en`=1. Otherwise `disp_en`=0 on that row.
- R5: `mag_sel` encodings are 0=off, 1=band of rows 0-11, 2=rows 6-11+6 (rows 6-17), 3=rows 12-23. For a main position p and scan s with magnify on, the row is base+p/2 and the scan is ((p%2)*10+s)/2, with `dbl_ht`=1. Status rows are never magnified.
- R6: Scroll N is applied after magnify. A source row r in 1..23 becomes 1+((r-1+N) mod 23). Row 0 and rows 24 and 25 are unchanged.
- R7: A `scroll_rows` value of 24 or more acts as 0.
- R8: `inhibit_disp`=1 blanks every row numbered 2 or more, including the status rows. Rows 0 and 1 stay displayed.
- R9: `update_key`=1 blanks every row numbered 1 or more. Row 0 stays displayed.
- R10: `suppress_hdr`=1 blanks row 0.
- R11: On row 0, `box_en`=1 in these cases: columns 0-7 when `box_page`=1, columns 8-31 when `box_head`=1, and columns 32-39 when `box_clock`=1. On rows 24 and 25, `box_en`=1 when `box_stat`=1. `box_en` is never 1 while `disp_en` is 0.
- R12: A `char_col` of 40 or more gives `disp_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel/character clock |
| rst | input | 1 | Synchronous active-high reset |
| tv_line | input | 10 | Current TV line number in the field |
| char_col | input | 6 | Current character column (0-39 valid) |
| mag_sel | input | 2 | Magnify band select (0 off, 1 top, 2 middle, 3 bottom) |
| scroll_rows | input | 5 | Upward scroll of rows 1-23 |
| stat_a_en | input | 1 | Show status row 24 |
| stat_b_en | input | 1 | Show status row 25 |
| inhibit_disp | input | 1 | Blank rows 2 and up |
| update_key | input | 1 | Blank rows 1 and up |
| suppress_hdr | input | 1 | Blank row 0 |
| box_page | input | 1 | Box row 0 columns 0-7 |
| box_head | input | 1 | Box row 0 columns 8-31 |
| box_clock | input | 1 | Box row 0 columns 32-39 |
| box_stat | input | 1 | Box the status rows |
| row_addr | output | 5 | Page-store row to fetch |
| cell_line | output | 4 | Scan line within the character cell |
| disp_en | output | 1 | Text displayed at this position |
| box_en | output | 1 | Position lies in an enabled box |
| dbl_ht | output | 1 | Magnified (double height) row |

## Verification
The assertions relate each output to the inputs one clock earlier through `$past`. They therefore assume that the inputs are stable across each capturing edge and free of X once reset is released. The bench meets this by changing every input on the falling edge and holding it there, and by driving all controls to known values before reset is released. The line and column inputs stay within their declared widths. The bench uses out-of-range columns and out-of-range scroll values on purpose to exercise R7 and R12.

// File: rtl/ttx_map_pkg.sv
package ttx_map_pkg;

  typedef enum logic [1:0] {
    MAG_OFF = 2'd0,
    MAG_TOP = 2'd1,
    MAG_MID = 2'd2,
    MAG_BOT = 2'd3
  } mag_e;

endpackage

// File: rtl/ttx_vwin.sv
module ttx_vwin #(
  parameter int LINE_W        = 10,
  parameter int ROW_W         = 5,
  parameter int SCAN_W        = 4,
  parameter int LINES_PER_ROW = 10,
  parameter int MAIN_ROWS     = 24,
  parameter int FIRST_NARROW  = 48,
  parameter int FIRST_WIDE    = 38
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic              wide_i,
  output logic              in_win_o,
  output logic [ROW_W-1:0]  pos_o,
  output logic [SCAN_W-1:0] scan_o
);
  localparam int LAST_NARROW = FIRST_NARROW + MAIN_ROWS * LINES_PER_ROW - 1;
  localparam int LAST_WIDE   = FIRST_WIDE + (MAIN_ROWS + 2) * LINES_PER_ROW - 1;

  logic [LINE_W-1:0] first, last, off;

  always_comb begin
    first    = wide_i ? LINE_W'(FIRST_WIDE) : LINE_W'(FIRST_NARROW);
    last     = wide_i ? LINE_W'(LAST_WIDE)  : LINE_W'(LAST_NARROW);
    in_win_o = (line_i >= first) && (line_i <= last);
    off      = line_i - first;
    pos_o    = ROW_W'(off / LINE_W'(LINES_PER_ROW));
    scan_o   = SCAN_W'(off % LINE_W'(LINES_PER_ROW));
  end
endmodule

// File: rtl/ttx_row_xlate.sv
module ttx_row_xlate
  import ttx_map_pkg::*;
#(
  parameter int ROW_W         = 5,
  parameter int SCAN_W        = 4,
  parameter int LINES_PER_ROW = 10,
  parameter int MAIN_ROWS     = 24
) (
  input  logic [ROW_W-1:0]  pos_i,
  input  logic [SCAN_W-1:0] scan_i,
  input  mag_e              mag_i,
  input  logic [ROW_W-1:0]  scroll_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [SCAN_W-1:0] scan_o,
  output logic              dbl_o
);
  localparam int BAND_STEP = MAIN_ROWS / 4;
  localparam int WRAP      = MAIN_ROWS - 1;

  logic [ROW_W-1:0]  scr, src;
  logic [ROW_W:0]    sum;
  logic [SCAN_W:0]   pair_line;

  always_comb begin
    scr       = (scroll_i >= ROW_W'(MAIN_ROWS)) ? '0 : scroll_i;
    src       = pos_i;
    scan_o    = scan_i;
    dbl_o     = 1'b0;
    pair_line = '0;
    if (pos_i < ROW_W'(MAIN_ROWS) && mag_i != MAG_OFF) begin
      src       = ROW_W'((int'(mag_i) - 1) * BAND_STEP) + (pos_i >> 1);
      pair_line = (pos_i[0] ? (SCAN_W+1)'(LINES_PER_ROW) : '0) + {1'b0, scan_i};
      scan_o    = SCAN_W'(pair_line >> 1);
      dbl_o     = 1'b1;
    end
    row_o = src;
    sum   = '0;
    if (src != '0 && src < ROW_W'(MAIN_ROWS)) begin
      sum = {1'b0, src} - 1'b1 + {1'b0, scr};
      if (sum >= (ROW_W+1)'(WRAP)) sum = sum - (ROW_W+1)'(WRAP);
      row_o = ROW_W'(sum + 1'b1);
    end
  end
endmodule

// File: rtl/ttx_box_ctl.sv
module ttx_box_ctl #(
  parameter int ROW_W      = 5,
  parameter int COL_W      = 6,
  parameter int N_COLS     = 40,
  parameter int MAIN_ROWS  = 24,
  parameter int HDR_COL0   = 8,
  parameter int CLK_COL0   = 32
) (
  input  logic             in_win_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             stat_a_i,
  input  logic             stat_b_i,
  input  logic             inhibit_i,
  input  logic             upd_key_i,
  input  logic             sup_hdr_i,
  input  logic             box_page_i,
  input  logic             box_head_i,
  input  logic             box_clock_i,
  input  logic             box_stat_i,
  output logic             show_o,
  output logic             box_o
);
  logic is_hdr, is_stat, hdr_box;

  always_comb begin
    is_hdr  = (row_i == '0);
    is_stat = (row_i >= ROW_W'(MAIN_ROWS));
    show_o  = in_win_i && (col_i < COL_W'(N_COLS))
              && !(is_hdr && sup_hdr_i)
              && !(row_i >= ROW_W'(1) && upd_key_i)
              && !(row_i >= ROW_W'(2) && inhibit_i)
              && !(row_i == ROW_W'(MAIN_ROWS)     && !stat_a_i)
              && !(row_i == ROW_W'(MAIN_ROWS + 1) && !stat_b_i);
    if (col_i < COL_W'(HDR_COL0))      hdr_box = box_page_i;
    else if (col_i < COL_W'(CLK_COL0)) hdr_box = box_head_i;
    else                               hdr_box = box_clock_i;
    box_o = show_o && ((is_hdr && hdr_box) || (is_stat && box_stat_i));
  end
endmodule

// File: rtl/ttx_row_mapper.sv
module ttx_row_mapper
  import ttx_map_pkg::*;
#(
  parameter int LINE_W        = 10,
  parameter int COL_W         = 6,
  parameter int ROW_W         = 5,
  parameter int SCAN_W        = 4,
  parameter int N_COLS        = 40,
  parameter int LINES_PER_ROW = 10,
  parameter int MAIN_ROWS     = 24,
  parameter int FIRST_NARROW  = 48,
  parameter int FIRST_WIDE    = 38
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] tv_line,
  input  logic [COL_W-1:0]  char_col,
  input  logic [1:0]        mag_sel,
  input  logic [ROW_W-1:0]  scroll_rows,
  input  logic              stat_a_en,
  input  logic              stat_b_en,
  input  logic              inhibit_disp,
  input  logic              update_key,
  input  logic              suppress_hdr,
  input  logic              box_page,
  input  logic              box_head,
  input  logic              box_clock,
  input  logic              box_stat,
  output logic [ROW_W-1:0]  row_addr,
  output logic [SCAN_W-1:0] cell_line,
  output logic              disp_en,
  output logic              box_en,
  output logic              dbl_ht
);
  logic              in_win, show, box, dbl;
  logic [ROW_W-1:0]  pos, row;
  logic [SCAN_W-1:0] pscan, rscan;

  ttx_vwin #(
    .LINE_W(LINE_W), .ROW_W(ROW_W), .SCAN_W(SCAN_W),
    .LINES_PER_ROW(LINES_PER_ROW), .MAIN_ROWS(MAIN_ROWS),
    .FIRST_NARROW(FIRST_NARROW), .FIRST_WIDE(FIRST_WIDE)
  ) vwin_i (
    .line_i(tv_line), .wide_i(stat_a_en | stat_b_en),
    .in_win_o(in_win), .pos_o(pos), .scan_o(pscan)
  );

  ttx_row_xlate #(
    .ROW_W(ROW_W), .SCAN_W(SCAN_W),
    .LINES_PER_ROW(LINES_PER_ROW), .MAIN_ROWS(MAIN_ROWS)
  ) xlate_i (
    .pos_i(pos), .scan_i(pscan), .mag_i(mag_e'(mag_sel)),
    .scroll_i(scroll_rows), .row_o(row), .scan_o(rscan), .dbl_o(dbl)
  );

  ttx_box_ctl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .N_COLS(N_COLS), .MAIN_ROWS(MAIN_ROWS)
  ) box_i (
    .in_win_i(in_win), .row_i(row), .col_i(char_col),
    .stat_a_i(stat_a_en), .stat_b_i(stat_b_en),
    .inhibit_i(inhibit_disp), .upd_key_i(update_key), .sup_hdr_i(suppress_hdr),
    .box_page_i(box_page), .box_head_i(box_head), .box_clock_i(box_clock),
    .box_stat_i(box_stat), .show_o(show), .box_o(box)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_addr  <= '0;
      cell_line <= '0;
      disp_en   <= 1'b0;
      box_en    <= 1'b0;
      dbl_ht    <= 1'b0;
    end else begin
      row_addr  <= show ? row   : '0;
      cell_line <= show ? rscan : '0;
      disp_en   <= show;
      box_en    <= box;
      dbl_ht    <= show && dbl;
    end
  end

  p_box_in_disp_r11: assert property (@(posedge clk) disable iff (rst)
    box_en |-> disp_en);
  p_row_range_r2: assert property (@(posedge clk) disable iff (rst)
    disp_en |-> row_addr < ROW_W'(MAIN_ROWS + 2));
  p_scan_range_r2: assert property (@(posedge clk) disable iff (rst)
    disp_en |-> cell_line < SCAN_W'(LINES_PER_ROW));
  p_stat_unmag_r5: assert property (@(posedge clk) disable iff (rst)
    (disp_en && row_addr >= ROW_W'(MAIN_ROWS)) |-> !dbl_ht);
  p_stat_a_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (disp_en && row_addr == ROW_W'(MAIN_ROWS)) |-> $past(stat_a_en));
  p_stat_b_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (disp_en && row_addr == ROW_W'(MAIN_ROWS + 1)) |-> $past(stat_b_en));
  p_inhibit_r8: assert property (@(posedge clk) disable iff (rst)
    (disp_en && $past(inhibit_disp)) |-> row_addr < ROW_W'(2));
  p_updkey_r9: assert property (@(posedge clk) disable iff (rst)
    (disp_en && $past(update_key)) |-> row_addr == '0);
  p_suphdr_r10: assert property (@(posedge clk) disable iff (rst)
    (disp_en && $past(suppress_hdr)) |-> row_addr != '0);
  p_col_limit_r12: assert property (@(posedge clk) disable iff (rst)
    disp_en |-> $past(char_col) < COL_W'(N_COLS));
endmodule

// File: tb/ttx_row_mapper_tb_top.sv
module ttx_row_mapper_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] tv_line = '0;
  logic [5:0] char_col = '0;
  logic [1:0] mag_sel = '0;
  logic [4:0] scroll_rows = '0;
  logic stat_a_en = 0, stat_b_en = 0, inhibit_disp = 0, update_key = 0;
  logic suppress_hdr = 0, box_page = 0, box_head = 0, box_clock = 0, box_stat = 0;
  logic [4:0] row_addr;
  logic [3:0] cell_line;
  logic disp_en, box_en, dbl_ht;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ttx_row_mapper dut_i (
    .clk(clk), .rst(rst), .tv_line(tv_line), .char_col(char_col),
    .mag_sel(mag_sel), .scroll_rows(scroll_rows),
    .stat_a_en(stat_a_en), .stat_b_en(stat_b_en),
    .inhibit_disp(inhibit_disp), .update_key(update_key),
    .suppress_hdr(suppress_hdr), .box_page(box_page), .box_head(box_head),
    .box_clock(box_clock), .box_stat(box_stat),
    .row_addr(row_addr), .cell_line(cell_line), .disp_en(disp_en),
    .box_en(box_en), .dbl_ht(dbl_ht)
  );

  // line, col, mag, scroll, exp row, exp scan, exp disp, exp dbl
  localparam logic [33:0] VEC [16] = '{
    {10'd48,  6'd0,  2'd0, 5'd0,  5'd0,  4'd0, 1'b1, 1'b0}, // R2 first line
    {10'd47,  6'd0,  2'd0, 5'd0,  5'd0,  4'd0, 1'b0, 1'b0}, // R2 before window
    {10'd287, 6'd39, 2'd0, 5'd0,  5'd23, 4'd9, 1'b1, 1'b0}, // R2 last line
    {10'd288, 6'd0,  2'd0, 5'd0,  5'd0,  4'd0, 1'b0, 1'b0}, // R2 after window
    {10'd125, 6'd5,  2'd0, 5'd0,  5'd7,  4'd7, 1'b1, 1'b0}, // R2 mid
    {10'd101, 6'd0,  2'd1, 5'd0,  5'd2,  4'd6, 1'b1, 1'b1}, // R5 top band
    {10'd48,  6'd0,  2'd2, 5'd0,  5'd6,  4'd0, 1'b1, 1'b1}, // R5 mid band
    {10'd287, 6'd0,  2'd3, 5'd0,  5'd23, 4'd9, 1'b1, 1'b1}, // R5 bottom band
    {10'd58,  6'd0,  2'd0, 5'd5,  5'd6,  4'd0, 1'b1, 1'b0}, // R6 scroll
    {10'd48,  6'd0,  2'd0, 5'd5,  5'd0,  4'd0, 1'b1, 1'b0}, // R6 row 0 fixed
    {10'd100, 6'd0,  2'd0, 5'd23, 5'd5,  4'd2, 1'b1, 1'b0}, // R6 full wrap
    {10'd278, 6'd0,  2'd0, 5'd5,  5'd5,  4'd0, 1'b1, 1'b0}, // R6 wrap to top
    {10'd100, 6'd0,  2'd0, 5'd30, 5'd5,  4'd2, 1'b1, 1'b0}, // R7 clamp 30
    {10'd58,  6'd0,  2'd0, 5'd24, 5'd1,  4'd0, 1'b1, 1'b0}, // R7 clamp 24
    {10'd68,  6'd0,  2'd2, 5'd3,  5'd10, 4'd0, 1'b1, 1'b1}, // R5 R6 combined
    {10'd100, 6'd40, 2'd0, 5'd0,  5'd0,  4'd0, 1'b0, 1'b0}  // R12 col 40
  };

  task automatic check(input string tag, input logic [4:0] er, input logic [3:0] es,
                       input logic ed, input logic eb, input logic eh);
    n_chk++;
    if (row_addr !== er || cell_line !== es || disp_en !== ed ||
        box_en !== eb || dbl_ht !== eh) begin
      n_bad++;
      $display("FAIL %s: got row=%0d scan=%0d disp=%b box=%b dbl=%b exp row=%0d scan=%0d disp=%b box=%b dbl=%b",
               tag, row_addr, cell_line, disp_en, box_en, dbl_ht, er, es, ed, eb, eh);
    end
  endtask

  task automatic step(input logic [9:0] ln, input logic [5:0] col);
    @(negedge clk);
    tv_line = ln; char_col = col;
    @(posedge clk); #1;
  endtask

  task automatic clr_ctl();
    @(negedge clk);
    mag_sel = 0; scroll_rows = 0; stat_a_en = 0; stat_b_en = 0;
    inhibit_disp = 0; update_key = 0; suppress_hdr = 0;
    box_page = 0; box_head = 0; box_clock = 0; box_stat = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tv_line = 10'd100;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", 0, 0, 0, 0, 0);
    @(negedge clk) rst = 0;

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      mag_sel = VEC[i][17:16]; scroll_rows = VEC[i][15:11];
      step(VEC[i][33:24], VEC[i][23:18]);
      check($sformatf("R2 R5 R6 R7 R12 table %0d", i),
            VEC[i][10:6], VEC[i][5:2], VEC[i][1], 1'b0, VEC[i][0]);
    end
    clr_ctl();

    // R3 / R4 wide window
    @(negedge clk) stat_a_en = 1;
    step(38, 0);  check("R3 wide first line", 0, 0, 1, 0, 0);
    step(37, 0);  check("R3 before wide", 0, 0, 0, 0, 0);
    step(277, 0); check("R3 row23 end", 23, 9, 1, 0, 0);
    step(278, 0); check("R3 status row 24", 24, 0, 1, 0, 0);
    step(288, 0); check("R4 row 25 hidden", 0, 0, 0, 0, 0);
    @(negedge clk) mag_sel = 1;
    step(278, 0); check("R5 status unmagnified", 24, 0, 1, 0, 0);
    step(38, 0);  check("R5 wide magnify row0", 0, 0, 1, 0, 1);
    @(negedge clk) begin mag_sel = 0; scroll_rows = 7; end
    step(278, 0); check("R6 status not scrolled", 24, 0, 1, 0, 0);
    @(negedge clk) begin scroll_rows = 0; stat_a_en = 0; stat_b_en = 1; end
    step(288, 0); check("R3 status row 25", 25, 0, 1, 0, 0);
    step(278, 0); check("R4 row 24 hidden", 0, 0, 0, 0, 0);
    step(297, 0); check("R3 wide last line", 25, 9, 1, 0, 0);
    step(298, 0); check("R3 after wide", 0, 0, 0, 0, 0);
    clr_ctl();

    // R8 / R9 / R10
    @(negedge clk) inhibit_disp = 1;
    step(58, 0);  check("R8 row1 kept", 1, 0, 1, 0, 0);
    step(68, 0);  check("R8 row2 blanked", 0, 0, 0, 0, 0);
    @(negedge clk) stat_a_en = 1;
    step(278, 0); check("R8 status blanked", 0, 0, 0, 0, 0);
    clr_ctl();
    @(negedge clk) update_key = 1;
    step(58, 0);  check("R9 row1 blanked", 0, 0, 0, 0, 0);
    step(48, 0);  check("R9 row0 kept", 0, 0, 1, 0, 0);
    clr_ctl();
    @(negedge clk) suppress_hdr = 1;
    step(48, 0);  check("R10 header blanked", 0, 0, 0, 0, 0);
    step(58, 0);  check("R10 row1 kept", 1, 0, 1, 0, 0);
    clr_ctl();

    // R11 boxing
    @(negedge clk) box_page = 1;
    step(48, 3);  check("R11 page box", 0, 0, 1, 1, 0);
    step(48, 8);  check("R11 header not boxed", 0, 0, 1, 0, 0);
    @(negedge clk) box_head = 1;
    step(48, 31); check("R11 header boxed", 0, 0, 1, 1, 0);
    step(48, 32); check("R11 clock not boxed", 0, 0, 1, 0, 0);
    @(negedge clk) box_clock = 1;
    step(48, 39); check("R11 clock boxed", 0, 0, 1, 1, 0);
    @(negedge clk) box_stat = 1;
    step(98, 5);  check("R11 main row not boxed", 5, 0, 1, 0, 0);
    @(negedge clk) stat_a_en = 1;
    step(278, 5); check("R11 status boxed", 24, 0, 1, 1, 0);
    @(negedge clk) suppress_hdr = 1;
    step(38, 3);  check("R11 no box while blanked", 0, 0, 0, 0, 0);
    clr_ctl();

    // R1 reset mid-run
    @(negedge clk) begin tv_line = 100; rst = 1; end
    @(posedge clk); #1 check("R1 reset mid-run", 0, 0, 0, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule